// File: doc/BRIEF.md
# General-Purpose Pin Port Controller

This block controls a port of up to sixteen general-purpose pins through a 32-bit word-wide register window. Each pin has a two-bit mode, an output type (push-pull or open-drain) and a two-bit pull setting. Every clock the block works out each pin's level from four things: its configuration, the stored output value, any external source that is currently attached, and the pull. That level is readable in a read-only input register and also leaves the block as one level line per pin, for an external interrupt or event controller.

External sources attach to a pin through a one-cycle strobe that carries a level. The block remembers whether a source is still attached to each pin. It detaches the source when output logic takes the pin over. A detached pin falls back to its pull, or, with no pull, to its last level. The attachment mask is brought out as a status port. Software can also change single output bits atomically, through a set/clear register in which set wins and through a clear-only register.

Top module: `pinport_ctrl`

## Requirements
- R1: After reset the mode register reads the MODE_RST parameter, the pull register reads PULL_RST, and the output-type and output-data registers read 0. With the defaults 0xABFFFFFF and 0x64000000 the input register reads 0x0000A000.
- R2: Register byte offsets are mode 0x00, output type 0x04, pull 0x0C, input 0x10, output data 0x14, set/clear 0x18 and clear 0x28. The set/clear register works per pin n: bit n sets output bit n, and bit n+16 clears it. When both bits are 1 the set wins. A 1 in bit n of the clear register clears output bit n.
- R3: A value written to the output data register while a pin is not in output mode is kept. It appears on the pin once the mode becomes output.
- R4: Pull codes are 00 none, 01 up, 10 down and 11 none. An input pin with no source attached reads 1 with pull-up and 0 with pull-down. An input pin with a source attached reads the source level, whatever the pull.
- R5: A pin in output mode (mode code 01) with output type 0 (push-pull) shows its output data bit. Its source is detached, and later strobes have no effect on it.
- R6: A pin in output mode with output type 1 (open-drain) reads 0 when its output bit is 0. When its output bit is 1 it keeps an attached low source and reads 0, but a high source is detached and cannot drive the pin high.
- R7: Mode codes 00, 10 and 11 all resolve as input.
- R8: The level lines equal the input register. A register write or strobe at one rising edge shows in both at that same edge.
- R9: Writes to the input register change no register and no pin level.
- R10: With FLOAT_HOLD set, a pin with no source attached, no pull and no output drive keeps its previous level.
- R11: The attachment status bit of a pin is 1 exactly while an external source is attached to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Word write strobe |
| bus_addr | input | ADDR_W | Byte address within the port window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_stb | input | NPINS | Per-pin strobe: an external source drives the pin |
| ext_lvl | input | NPINS | Level carried by each strobe |
| pin_level | output | NPINS | Resolved pin levels toward the interrupt block |
| ext_valid | output | NPINS | Per-pin external-attachment status |

## Verification
A wrong attachment bit stays hidden until the pin is left to float or to an open-drain release. It then shows up as a stale external level on pin_level, possibly many cycles later. For that reason ext_valid is compared against the model on every cycle, and so is pin_level. A corrupt output or mode register shows within one edge, on the level line of any pin that is driving. Merging the set/clear fields in the wrong order shows only in the cycle when both fields of a pin are 1, so the bench exercises that case on purpose.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

   typedef enum logic [1:0] {
      MODE_IN  = 2'b00,
      MODE_OUT = 2'b01,
      MODE_ALT = 2'b10,
      MODE_ANA = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      PULL_NONE = 2'b00,
      PULL_UP   = 2'b01,
      PULL_DOWN = 2'b10,
      PULL_RSVD = 2'b11
   } pin_pull_e;

   // per-pin configuration as seen after the current write
   typedef struct packed {
      logic [1:0] mode;
      logic       od;
      logic [1:0] pull;
      logic       odr;
   } pin_cfg_t;

   // byte offsets inside the port window
   localparam int OFS_MODE  = 'h00;
   localparam int OFS_TYPE  = 'h04;
   localparam int OFS_PULL  = 'h0C;
   localparam int OFS_IN    = 'h10;
   localparam int OFS_OUT   = 'h14;
   localparam int OFS_SETCL = 'h18;
   localparam int OFS_CLR   = 'h28;
   localparam int CLR_LSB   = 16;

   // may an external source stay attached under this configuration
   function automatic logic pin_keep_ext(pin_cfg_t c, logic ev);
      logic drives;
      drives = (c.mode == MODE_OUT);
      return !(drives && (!c.od || ev));
   endfunction

   // level of one pin
   function automatic logic pin_resolve(pin_cfg_t c, logic conn, logic ev, logic flt);
      logic drives;
      drives = (c.mode == MODE_OUT);
      if (drives && !c.od)  return c.odr;
      if (drives && !c.odr) return 1'b0;
      if (conn)             return ev;
      case (c.pull)
         PULL_UP:   return 1'b1;
         PULL_DOWN: return 1'b0;
         default:   return flt;
      endcase
   endfunction

endpackage

// File: rtl/pinport_regs.sv
module pinport_regs
   import pinport_pkg::*;
#(
   parameter int          NPINS    = 16,
   parameter int          ADDR_W   = 10,
   parameter logic [31:0] MODE_RST = 32'hABFF_FFFF,
   parameter logic [31:0] PULL_RST = 32'h6400_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [NPINS-1:0]     pin_in,
   output logic [31:0]          bus_rdata,
   output pin_cfg_t [NPINS-1:0] cfg_nxt,
   output logic [2*NPINS-1:0]   mode_q,
   output logic [NPINS-1:0]     od_q,
   output logic [NPINS-1:0]     odr_q
);

   localparam int WORD_W = ADDR_W - 2;
   localparam int MW     = 2 * NPINS;

   logic [WORD_W-1:0] word;
   logic [1:0]        unused_lsb;
   logic [MW-1:0]     pull_q, mode_n, pull_n;
   logic [NPINS-1:0]  od_n, odr_n;

   assign word       = bus_addr[ADDR_W-1:2];
   assign unused_lsb = bus_addr[1:0];

   function automatic logic at(int ofs);
      return word == WORD_W'(ofs >> 2);
   endfunction

   always_comb begin
      mode_n = mode_q;
      pull_n = pull_q;
      od_n   = od_q;
      odr_n  = odr_q;
      if (bus_wr) begin
         if (at(OFS_MODE))  mode_n = bus_wdata[MW-1:0];
         if (at(OFS_PULL))  pull_n = bus_wdata[MW-1:0];
         if (at(OFS_TYPE))  od_n   = bus_wdata[NPINS-1:0];
         if (at(OFS_OUT))   odr_n  = bus_wdata[NPINS-1:0];
         // clear field applied first so the set field wins
         if (at(OFS_SETCL)) odr_n  = (odr_q & ~bus_wdata[CLR_LSB +: NPINS])
                                     | bus_wdata[NPINS-1:0];
         if (at(OFS_CLR))   odr_n  = odr_q & ~bus_wdata[NPINS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST[MW-1:0];
         pull_q <= PULL_RST[MW-1:0];
         od_q   <= '0;
         odr_q  <= '0;
      end else begin
         mode_q <= mode_n;
         pull_q <= pull_n;
         od_q   <= od_n;
         odr_q  <= odr_n;
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_cfg
      assign cfg_nxt[i].mode = mode_n[2*i +: 2];
      assign cfg_nxt[i].od   = od_n[i];
      assign cfg_nxt[i].pull = pull_n[2*i +: 2];
      assign cfg_nxt[i].odr  = odr_n[i];
   end

   always_comb begin
      bus_rdata = '0;
      if (at(OFS_MODE)) bus_rdata[MW-1:0]    = mode_q;
      if (at(OFS_PULL)) bus_rdata[MW-1:0]    = pull_q;
      if (at(OFS_TYPE)) bus_rdata[NPINS-1:0] = od_q;
      if (at(OFS_OUT))  bus_rdata[NPINS-1:0] = odr_q;
      if (at(OFS_IN))   bus_rdata[NPINS-1:0] = pin_in;
   end

endmodule

// File: rtl/pinport_pin.sv
module pinport_pin
   import pinport_pkg::*;
#(
   parameter logic [1:0] RST_MODE   = 2'b11,
   parameter logic [1:0] RST_PULL   = 2'b00,
   parameter bit         FLOAT_HOLD = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg_nxt,
   input  logic     ext_stb,
   input  logic     ext_lvl,
   output logic     level_q,
   output logic     conn_q
);

   localparam logic LVL_RST = (RST_MODE != MODE_OUT) && (RST_PULL == PULL_UP);

   logic ev_q, ev_n, conn_n, flt, level_n;

   if (FLOAT_HOLD) begin : g_hold
      assign flt = level_q;
   end else begin : g_zero
      assign flt = 1'b0;
   end

   always_comb begin
      ev_n    = ext_stb ? ext_lvl : ev_q;
      conn_n  = (ext_stb || conn_q) && pin_keep_ext(cfg_nxt, ev_n);
      level_n = pin_resolve(cfg_nxt, conn_n, ev_n, flt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_RST;
         conn_q  <= 1'b0;
         ev_q    <= 1'b0;
      end else begin
         level_q <= level_n;
         conn_q  <= conn_n;
         ev_q    <= ev_n;
      end
   end

endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
   import pinport_pkg::*;
#(
   parameter int          NPINS      = 16,
   parameter int          ADDR_W     = 10,
   parameter logic [31:0] MODE_RST   = 32'hABFF_FFFF,
   parameter logic [31:0] PULL_RST   = 32'h6400_0000,
   parameter bit          FLOAT_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  ext_stb,
   input  logic [NPINS-1:0]  ext_lvl,
   output logic [NPINS-1:0]  pin_level,
   output logic [NPINS-1:0]  ext_valid
);

   if (NPINS < 1 || NPINS > CLR_LSB) begin : g_bad_npins
      $error("pinport_ctrl: NPINS must lie in 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("pinport_ctrl: ADDR_W too small for the register window");
   end

   pin_cfg_t [NPINS-1:0]   cfg_nxt;
   logic [2*NPINS-1:0]     mode_q;
   logic [NPINS-1:0]       od_q, odr_q;

   pinport_regs #(
      .NPINS   (NPINS),
      .ADDR_W  (ADDR_W),
      .MODE_RST(MODE_RST),
      .PULL_RST(PULL_RST)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .pin_in   (pin_level),
      .bus_rdata(bus_rdata),
      .cfg_nxt  (cfg_nxt),
      .mode_q   (mode_q),
      .od_q     (od_q),
      .odr_q    (odr_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pinport_pin #(
         .RST_MODE  (MODE_RST[2*i +: 2]),
         .RST_PULL  (PULL_RST[2*i +: 2]),
         .FLOAT_HOLD(FLOAT_HOLD)
      ) pin_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .cfg_nxt(cfg_nxt[i]),
         .ext_stb(ext_stb[i]),
         .ext_lvl(ext_lvl[i]),
         .level_q(pin_level[i]),
         .conn_q (ext_valid[i])
      );
   end

endmodule

// File: rtl/pinport_chk.sv
module pinport_chk #(
   parameter int NPINS  = 16,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [2*NPINS-1:0] mode_q,
   input logic [NPINS-1:0]  od_q,
   input logic [NPINS-1:0]  odr_q,
   input logic [NPINS-1:0]  pin_level,
   input logic [NPINS-1:0]  ext_valid
);

   logic wr_setcl, wr_in;
   assign wr_setcl = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h18 >> 2));
   assign wr_in    = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'('h10 >> 2));

   // R9
   in_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in |=> ($stable(odr_q) && $stable(mode_q) && $stable(od_q)));

   for (genvar i = 0; i < NPINS; i++) begin : g_chk
      logic drv;
      assign drv = (mode_q[2*i +: 2] == 2'b01);

      // R5
      pushpull_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (drv && !od_q[i]) |-> (pin_level[i] == odr_q[i] && !ext_valid[i]));

      // R6
      od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (drv && od_q[i] && !odr_q[i]) |-> !pin_level[i]);

      // R6
      od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (drv && od_q[i] && ext_valid[i]) |-> !pin_level[i]);

      // R2
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_setcl && bus_wdata[i]) |=> odr_q[i]);
   end

endmodule

bind pinport_ctrl pinport_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .mode_q   (mode_q),
   .od_q     (od_q),
   .odr_q    (odr_q),
   .pin_level(pin_level),
   .ext_valid(ext_valid)
);

// File: tb/pinport_ctrl_tb_top.sv
`timescale 1ns/1ps
module pinport_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0;
   logic [9:0]  b_addr = '0;
   logic [31:0] b_wdata = '0;
   logic [31:0] b_rdata;
   logic [15:0] e_stb = '0, e_lvl = '0;
   logic [15:0] lvl, valid;

   int n_chk = 0, n_bad = 0;

   // reference state
   logic [31:0] m_mode, m_pull;
   logic [15:0] m_type, m_odr, m_conn, m_ev, m_lvl;

   always #10 clk = ~clk;

   pinport_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
      .bus_wdata(b_wdata), .bus_rdata(b_rdata), .ext_stb(e_stb),
      .ext_lvl(e_lvl), .pin_level(lvl), .ext_valid(valid)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: model advances with the driven inputs, outputs compared after the edge
   task automatic step();
      logic [31:0] nm, np;
      logic [15:0] nt, no, nc, ne, nl;
      nm = m_mode; np = m_pull; nt = m_type; no = m_odr;
      if (b_wr) begin
         case (b_addr[9:2])
            8'd0:  nm = b_wdata;
            8'd1:  nt = b_wdata[15:0];
            8'd3:  np = b_wdata;
            8'd5:  no = b_wdata[15:0];
            8'd6:  no = (no & ~b_wdata[31:16]) | b_wdata[15:0];
            8'd10: no = no & ~b_wdata[15:0];
            default: ;
         endcase
      end
      for (int i = 0; i < 16; i++) begin
         bit pp, od, c, e, l;
         pp = (nm[2*i +: 2] == 2'b01) && !nt[i];
         od = (nm[2*i +: 2] == 2'b01) && nt[i];
         c = m_conn[i]; e = m_ev[i];
         if (e_stb[i]) begin c = 1; e = e_lvl[i]; end
         if (pp) c = 0;
         if (od && e) c = 0;
         if (pp) l = no[i];
         else if (od && !no[i]) l = 0;
         else if (c) l = e;
         else if (np[2*i +: 2] == 2'b01) l = 1;
         else if (np[2*i +: 2] == 2'b10) l = 0;
         else l = m_lvl[i];
         nc[i] = c; ne[i] = e; nl[i] = l;
      end
      @(negedge clk);
      m_mode = nm; m_pull = np; m_type = nt; m_odr = no;
      m_conn = nc; m_ev = ne; m_lvl = nl;
      chk("R8 level", {16'h0, lvl}, {16'h0, m_lvl});
      chk("R11 attach", {16'h0, valid}, {16'h0, m_conn});
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d);
      b_wr = 1; b_addr = a; b_wdata = d;
      step();
      b_wr = 0; b_wdata = '0;
   endtask

   task automatic drive(int pin, bit v);
      e_stb = '0; e_lvl = '0;
      e_stb[pin] = 1'b1; e_lvl[pin] = v;
      step();
      e_stb = '0; e_lvl = '0;
   endtask

   task automatic rd(string tag, logic [9:0] a, logic [31:0] exp);
      b_addr = a;
      #1;
      chk(tag, b_rdata, exp);
   endtask

   function automatic logic [31:0] put2(logic [31:0] r, int p, logic [1:0] v);
      r[2*p +: 2] = v;
      return r;
   endfunction

   initial begin : watchdog
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      m_mode = 32'hABFF_FFFF; m_pull = 32'h6400_0000;
      m_type = '0; m_odr = '0; m_conn = '0; m_ev = '0; m_lvl = '0;
      for (int i = 0; i < 16; i++)
         m_lvl[i] = (m_mode[2*i +: 2] != 2'b01) && (m_pull[2*i +: 2] == 2'b01);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd("R1 mode", 10'h00, 32'hABFF_FFFF);
      rd("R1 pull", 10'h0C, 32'h6400_0000);
      rd("R1 type", 10'h04, 32'h0);
      rd("R1 out",  10'h14, 32'h0);
      rd("R1 in",   10'h10, 32'h0000_A000);
      chk("R1 level", {16'h0, lvl}, 32'h0000_A000);
      step();

      // R3 output value stored while pin 5 is analog, applied on mode change
      wr(10'h14, 32'h20);
      rd("R3 held", 10'h10, 32'h0000_A000);
      rd("R3 out", 10'h14, 32'h20);
      wr(10'h00, put2(m_mode, 5, 2'b01));
      rd("R3 applied", 10'h10, 32'h0000_A020);

      // R2 atomic set and clear
      wr(10'h18, 32'h1 << 3);
      rd("R2 set", 10'h14, 32'h28);
      wr(10'h18, 32'h1 << 21);
      rd("R2 clear", 10'h14, 32'h08);
      wr(10'h18, (32'h1 << 5) | (32'h1 << 21));
      rd("R2 set wins", 10'h14, 32'h28);
      wr(10'h28, 32'h1 << 3);
      rd("R2 clr reg", 10'h14, 32'h20);
      rd("R2 pin5 high", 10'h10, 32'h0000_A020);
      wr(10'h28, 32'h1 << 5);
      rd("R2 pin5 low", 10'h10, 32'h0000_A000);

      // R7 analog pin 6 follows a source; R4 source beats pull
      drive(6, 1);
      rd("R7 analog ext high", 10'h10, 32'h0000_A040);
      drive(6, 0);
      rd("R7 analog ext low", 10'h10, 32'h0000_A000);
      wr(10'h00, put2(m_mode, 6, 2'b00));
      wr(10'h0C, put2(m_pull, 6, 2'b01));
      rd("R4 ext over pull", 10'h10, 32'h0000_A000);
      chk("R11 pin6 attached", {31'h0, valid[6]}, 32'h1);

      // R4 floating pulls on pin 7, R10 hold with no pull
      wr(10'h00, put2(m_mode, 7, 2'b00));
      wr(10'h0C, put2(m_pull, 7, 2'b01));
      rd("R4 pull-up", 10'h10, 32'h0000_A080);
      wr(10'h0C, put2(m_pull, 7, 2'b10));
      rd("R4 pull-down", 10'h10, 32'h0000_A000);
      wr(10'h0C, put2(m_pull, 7, 2'b01));
      wr(10'h0C, put2(m_pull, 7, 2'b00));
      rd("R10 hold high", 10'h10, 32'h0000_A080);
      wr(10'h0C, put2(m_pull, 7, 2'b11));
      rd("R10 reserved pull holds", 10'h10, 32'h0000_A080);

      // R5 push-pull on pin 8 detaches a high source
      drive(8, 1);
      chk("R11 pin8 attached", {31'h0, valid[8]}, 32'h1);
      wr(10'h00, put2(m_mode, 8, 2'b01));
      chk("R5 detached", {31'h0, valid[8]}, 32'h0);
      chk("R5 follows out", {31'h0, lvl[8]}, 32'h0);
      drive(8, 1);
      chk("R5 strobe ignored", {31'h0, lvl[8]}, 32'h0);
      wr(10'h18, 32'h1 << 8);
      chk("R5 drives high", {31'h0, lvl[8]}, 32'h1);
      drive(8, 0);
      chk("R5 low strobe ignored", {31'h0, lvl[8]}, 32'h1);

      // R6 open-drain: pin 9 keeps low source, pin 10 drops high source
      drive(9, 0);
      wr(10'h18, 32'h1 << 9);
      wr(10'h04, 32'h1 << 9);
      wr(10'h00, put2(m_mode, 9, 2'b01));
      chk("R6 low kept", {31'h0, valid[9]}, 32'h1);
      chk("R6 reads low", {31'h0, lvl[9]}, 32'h0);
      wr(10'h0C, put2(m_pull, 10, 2'b10));
      drive(10, 1);
      chk("R6 pin10 high before", {31'h0, lvl[10]}, 32'h1);
      wr(10'h18, 32'h1 << 10);
      wr(10'h04, m_type | (32'h1 << 10));
      wr(10'h00, put2(m_mode, 10, 2'b01));
      chk("R6 high dropped", {31'h0, valid[10]}, 32'h0);
      chk("R6 pin10 low", {31'h0, lvl[10]}, 32'h0);
      drive(10, 1);
      chk("R6 cannot raise", {31'h0, lvl[10]}, 32'h0);
      wr(10'h28, 32'h1 << 9);
      chk("R6 out zero low", {31'h0, lvl[9]}, 32'h0);

      // R9 writes to the input register are inert
      wr(10'h10, 32'hFFFF_FFFF);
      rd("R9 in unchanged", 10'h10, {16'h0, m_lvl});
      rd("R9 out unchanged", 10'h14, {16'h0, m_odr});
      rd("R9 mode unchanged", 10'h00, m_mode);

      repeat (3) step();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule